// File: doc/BRIEF.md
# Memory Row Boundary Decoder

The decoder routes a physical request address to one of four memory rows, each row being a chip-select group. Every row owns an 8-bit boundary register that holds the row's upper limit in units of 16 MB. The limits are cumulative, so each row begins at the limit of the row below it, and row 0 begins at address zero. A row whose range works out empty is never selected.

Software-side logic loads the four boundaries through a simple write port: an enable, a row select and a data byte. The decode path is purely combinational from the registered boundaries and the request address. It drives a one-hot chip-select vector, the binary index of the selected row, and a miss flag for addresses that no row covers. Reset clears every boundary, which leaves every address unmapped until the boundaries are programmed.

Top module: `row_boundary_decoder`

## Requirements
- R1: When `bnd_wr_en` is high at a rising edge, boundary number `bnd_wr_sel` takes `bnd_wr_data` at that edge. Decoding before that edge uses the old value and decoding after it uses the new one. Boundaries that are not written keep their values.
- R2: Reset sets all four boundaries to 0. After reset every address raises `addr_miss`, `row_cs` is all zero and `row_idx` is 0.
- R3: Row 0 covers addresses from 0 up to, but not including, boundary0 × 2^24.
- R4: Row n (n = 1..3) covers addresses from boundary(n-1) × 2^24 up to, but not including, boundary(n) × 2^24. Address bits 23:0 never affect the result.
- R5: A row whose boundary equals the boundary below it is never selected. For row 0, this means boundary0 equals 0.
- R6: A row whose boundary is below the boundary of the row beneath it covers no address.
- R7: At most one bit of `row_cs` is high. Bit n of `row_cs` (LSB = row 0) is set only for the selected row. `row_idx` carries the binary number of that row, and `row_idx` is 0 when no row is selected.
- R8: When the ranges of two rows overlap, because the boundaries are not ascending, the lower-numbered row wins.
- R9: `addr_miss` is high exactly when no row covers the address, and `row_cs` is then all zero. This includes every address at or above the highest boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the boundary registers |
| rst | input | 1 | Synchronous active-high reset, clears all boundaries |
| bnd_wr_en | input | 1 | Boundary write strobe |
| bnd_wr_sel | input | 2 | Row whose boundary is written |
| bnd_wr_data | input | 8 | New upper limit, in 16 MB units |
| req_addr | input | 32 | Physical request address |
| row_cs | output | 4 | One-hot row select, bit n = row n |
| row_idx | output | 2 | Binary index of the selected row |
| addr_miss | output | 1 | No row covers the request address |

## Verification
A boundary write and a decode that depends on the boundary being written can occur in the same cycle. The bench provokes this by holding a new boundary on the write port while it presents an address that lies between the old and new limits. Before the clock edge the outputs must still show the old mapping. After the edge the same address must move to the neighbouring row. Every other boundary configuration is judged by sweeping all 256 values of address bits 31:24, with scattered low bits, against a range model computed in full 32-bit addresses.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;
    localparam int DEF_ROWS       = 4;
    localparam int DEF_ADDR_W     = 32;
    localparam int DEF_GRAN_SHIFT = 24;
endpackage

// File: rtl/rowdec_bound_regs.sv
module rowdec_bound_regs #(
    parameter int NUM_ROWS = 4,
    parameter int BOUND_W  = 8,
    parameter int IDX_W    = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_sel,
    input  logic [BOUND_W-1:0]                wr_data,
    output logic [NUM_ROWS-1:0][BOUND_W-1:0]  bounds_q
);
    for (genvar n = 0; n < NUM_ROWS; n++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                bounds_q[n] <= '0;
            else if (wr_en && wr_sel == IDX_W'(n))
                bounds_q[n] <= wr_data;
        end
    end
endmodule

// File: rtl/rowdec_row_match.sv
module rowdec_row_match #(
    parameter int BOUND_W = 8
) (
    input  logic [BOUND_W-1:0] base,
    input  logic [BOUND_W-1:0] limit,
    input  logic [BOUND_W-1:0] addr_hi,
    output logic               hit
);
    always_comb begin
        hit = (addr_hi >= base) && (addr_hi < limit);
    end
endmodule

// File: rtl/rowdec_first_hit.sv
module rowdec_first_hit #(
    parameter int NUM_ROWS = 4,
    parameter int IDX_W    = 2
) (
    input  logic [NUM_ROWS-1:0] hits,
    output logic [NUM_ROWS-1:0] cs,
    output logic [IDX_W-1:0]    idx,
    output logic                none
);
    always_comb begin
        cs  = '0;
        idx = '0;
        for (int n = NUM_ROWS - 1; n >= 0; n--) begin
            if (hits[n]) begin
                cs     = '0;
                cs[n]  = 1'b1;
                idx    = IDX_W'(n);
            end
        end
        none = ~|hits;
    end
endmodule

// File: rtl/row_boundary_decoder.sv
module row_boundary_decoder
    import rowdec_pkg::*;
#(
    parameter int NUM_ROWS   = DEF_ROWS,
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int GRAN_SHIFT = DEF_GRAN_SHIFT,
    localparam int BOUND_W   = ADDR_W - GRAN_SHIFT,
    localparam int IDX_W     = $clog2(NUM_ROWS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bnd_wr_en,
    input  logic [IDX_W-1:0]    bnd_wr_sel,
    input  logic [BOUND_W-1:0]  bnd_wr_data,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic [NUM_ROWS-1:0] row_cs,
    output logic [IDX_W-1:0]    row_idx,
    output logic                addr_miss
);
    logic [NUM_ROWS-1:0][BOUND_W-1:0] bounds_q;
    logic [NUM_ROWS-1:0]              row_hit;
    logic [BOUND_W-1:0]               addr_hi;
    logic                             addr_lo_unused;

    assign addr_hi        = req_addr[ADDR_W-1:GRAN_SHIFT];
    assign addr_lo_unused = ^req_addr[GRAN_SHIFT-1:0];

    rowdec_bound_regs #(
        .NUM_ROWS (NUM_ROWS),
        .BOUND_W  (BOUND_W),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bnd_wr_en),
        .wr_sel   (bnd_wr_sel),
        .wr_data  (bnd_wr_data),
        .bounds_q (bounds_q)
    );

    for (genvar n = 0; n < NUM_ROWS; n++) begin : g_row
        logic [BOUND_W-1:0] row_base;
        if (n == 0) begin : g_first
            assign row_base = '0;
        end else begin : g_next
            assign row_base = bounds_q[n-1];
        end
        rowdec_row_match #(
            .BOUND_W (BOUND_W)
        ) u_match (
            .base    (row_base),
            .limit   (bounds_q[n]),
            .addr_hi (addr_hi),
            .hit     (row_hit[n])
        );
    end

    rowdec_first_hit #(
        .NUM_ROWS (NUM_ROWS),
        .IDX_W    (IDX_W)
    ) u_pick (
        .hits (row_hit),
        .cs   (row_cs),
        .idx  (row_idx),
        .none (addr_miss)
    );
endmodule

// File: rtl/rowdec_checker.sv
module rowdec_checker #(
    parameter int NUM_ROWS = 4,
    parameter int BOUND_W  = 8,
    parameter int IDX_W    = 2
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             wr_en,
    input logic [IDX_W-1:0]                 wr_sel,
    input logic [BOUND_W-1:0]               wr_data,
    input logic [NUM_ROWS-1:0][BOUND_W-1:0] bounds,
    input logic [NUM_ROWS-1:0]              cs,
    input logic [IDX_W-1:0]                 idx,
    input logic                             miss
);
    assert_cs_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs));

    assert_idx_points_R7: assert property (@(posedge clk) disable iff (rst)
        (|cs) |-> cs[idx]);

    assert_idx_zero_R7: assert property (@(posedge clk) disable iff (rst)
        miss |-> (idx == '0));

    assert_miss_matches_R9: assert property (@(posedge clk) disable iff (rst)
        miss == (cs == '0));

    assert_write_lands_R1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> bounds[$past(wr_sel)] == $past(wr_data));

    assert_no_write_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(bounds));

    assert_reset_clears_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (bounds == '0));

    for (genvar n = 0; n < NUM_ROWS; n++) begin : g_chk
        logic [BOUND_W-1:0] lower;
        if (n == 0) begin : g_first
            assign lower = '0;
        end else begin : g_next
            assign lower = bounds[n-1];
        end
        assert_empty_row_R5: assert property (@(posedge clk) disable iff (rst)
            (bounds[n] <= lower) |-> !cs[n]);
    end
endmodule

bind row_boundary_decoder rowdec_checker #(
    .NUM_ROWS (NUM_ROWS),
    .BOUND_W  (BOUND_W),
    .IDX_W    (IDX_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bnd_wr_en),
    .wr_sel  (bnd_wr_sel),
    .wr_data (bnd_wr_data),
    .bounds  (bounds_q),
    .cs      (row_cs),
    .idx     (row_idx),
    .miss    (addr_miss)
);

// File: tb/sim_row_boundary_decoder.sv
module sim_row_boundary_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bnd_wr_en = 1'b0;
    logic [1:0]  bnd_wr_sel = '0;
    logic [7:0]  bnd_wr_data = '0;
    logic [31:0] req_addr = '0;
    logic [3:0]  row_cs;
    logic [1:0]  row_idx;
    logic        addr_miss;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] mdl [4];

    always #10 clk = ~clk;

    row_boundary_decoder u0 (
        .clk         (clk),
        .rst         (rst),
        .bnd_wr_en   (bnd_wr_en),
        .bnd_wr_sel  (bnd_wr_sel),
        .bnd_wr_data (bnd_wr_data),
        .req_addr    (req_addr),
        .row_cs      (row_cs),
        .row_idx     (row_idx),
        .addr_miss   (addr_miss)
    );

    // expected row from full 32-bit ranges; -1 means no row
    function automatic int model_row(logic [31:0] a);
        for (int n = 0; n < 4; n++) begin
            longint lo = (n == 0) ? 0 : longint'(mdl[n-1]) * 64'd16777216;
            longint hi = longint'(mdl[n]) * 64'd16777216;
            if (longint'(a) >= lo && longint'(a) < hi) return n;
        end
        return -1;
    endfunction

    task automatic check_now(string tag);
        int e = model_row(req_addr);
        logic [3:0] e_cs  = (e < 0) ? 4'b0 : 4'(1 << e);
        logic [1:0] e_idx = (e < 0) ? 2'd0 : 2'(e);
        logic       e_miss = (e < 0);
        n_chk++;
        if (row_cs !== e_cs || row_idx !== e_idx || addr_miss !== e_miss) begin
            n_fail++;
            $display("FAIL %s addr=%h actual cs=%b idx=%0d miss=%b expected cs=%b idx=%0d miss=%b",
                     tag, req_addr, row_cs, row_idx, addr_miss, e_cs, e_idx, e_miss);
        end
    endtask

    task automatic sweep(string tag);
        for (int a = 0; a < 256; a++) begin
            @(negedge clk);
            req_addr = {a[7:0], 24'(a * 40503 + 7)};
            #5;
            check_now(tag);
        end
    endtask

    task automatic wr(int sel, logic [7:0] val);
        @(negedge clk);
        bnd_wr_en   = 1'b1;
        bnd_wr_sel  = 2'(sel);
        bnd_wr_data = val;
        @(negedge clk);
        bnd_wr_en = 1'b0;
        mdl[sel]  = val;
    endtask

    task automatic load(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2, logic [7:0] b3);
        wr(0, b0); wr(1, b1); wr(2, b2); wr(3, b3);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int n = 0; n < 4; n++) mdl[n] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        sweep("R2 reset all miss");
        load(8'h10, 8'h30, 8'h50, 8'h80);
        sweep("R3 R4 ascending rows");
        load(8'h10, 8'h10, 8'h50, 8'h80);
        sweep("R5 empty middle row");
        load(8'h00, 8'h20, 8'h20, 8'hFF);
        sweep("R5 empty first row");
        load(8'h10, 8'h40, 8'h20, 8'h30);
        sweep("R6 R8 descending overlap");
        load(8'h40, 8'h80, 8'hC0, 8'hFF);
        sweep("R9 R7 full map top miss");

        // R1: write and dependent decode in the same cycle
        @(negedge clk);
        bnd_wr_en   = 1'b1;
        bnd_wr_sel  = 2'd0;
        bnd_wr_data = 8'h20;
        req_addr    = 32'h30AB_CDEF;
        #5;
        check_now("R1 old bound before edge");
        @(negedge clk);
        bnd_wr_en = 1'b0;
        mdl[0]    = 8'h20;
        #5;
        check_now("R1 new bound after edge");
        sweep("R1 R4 after single write");

        // R2: reset again from a programmed state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int n = 0; n < 4; n++) mdl[n] = 8'h00;
        sweep("R2 reset clears programmed map");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule